// File: doc/BRIEF.md
# Keyed Configuration Port with GPIO Device Bank

This block gives a host a small configuration space reached through a pair of byte ports: an index port and a data port. The host writes a register number to the index port, then reads or writes that register through the data port. The space stays closed until a fixed four-byte key arrives on the index port. While closed, the data port reads as all ones and drops writes. One specific data-port write closes the space again.

Inside the space there is a logical-device selector, read-only chip identity and revision bytes, and one device bank that holds GPIO setup. The GPIO setup is a 16-bit I/O base address, per-group output-enable bytes and per-group simple-mode enable bytes. The bank is visible only while the selector holds the GPIO device number. The bank contents drive output pins that feed the GPIO logic beside this block. The host strobes are single-cycle and synchronous. Read data is registered and arrives with a valid flag one cycle after the read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: The configuration space opens (cfg_mode high) only after the index port receives the writes 0x87, 0x01, 0x55, 0x55 in that order. cfg_mode rises in the cycle after the fourth write strobe and stays low after each of the first three.
- R2: While closed, an index write that does not match the next key byte sends the key tracker back to its start. If that wrong byte is 0x87, it counts as the first key byte, so 0x87 0x87 0x01 0x55 0x55 and 0x87 0x01 0x87 0x01 0x55 0x55 both open the space.
- R3: While closed, every data-port read returns 0xFF and data-port writes change no register.
- R4: While open, a data write of 0x02 when the index holds 0x02 closes the space. Any other value written to register 0x02 has no effect.
- R5: Register 0x07 is the logical-device selector. It reads back the last value written to it.
- R6: Registers 0x20 and 0x21 return the chip ID high byte and low byte (parameter, default 0x8728). Register 0x22 returns the revision in bits [3:0] and zero in bits [7:4]. Writes to all three registers are ignored.
- R7: With device 0x07 selected, registers 0x62 (high byte) and 0x63 (low byte) hold the GPIO base. The gpio_base output equals {reg 0x62, reg 0x63} from the cycle after a write.
- R8: With device 0x07 selected, register 0xC8+g holds the output-enable byte of group g and drives gpio_oe[8g+7:8g]. Register 0xC0+g holds the simple-mode byte of group g and drives gpio_simple[8g+7:8g].
- R9: With any other device selected, or at any unmapped register number, data reads return 0x00. Writes to GPIO bank numbers are then ignored.
- R10: io_rvalid is high in exactly the cycle after an io_rd strobe to the index or data port. io_rdata is valid in that cycle.
- R11: An index-port read returns the current index register while open, and 0xFF while closed.
- R12: After reset the space is closed, and the index, selector and every GPIO bank register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_addr | input | ADDR_W | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read byte |
| io_rvalid | output | 1 | Read byte valid, one cycle after io_rd |
| cfg_mode | output | 1 | High while the configuration space is open |
| gpio_base | output | 16 | GPIO I/O base address |
| gpio_oe | output | NUM_GROUPS*8 | Output-enable bits, one byte per group |
| gpio_simple | output | NUM_SIMPLE*8 | Simple-mode enable bits, one byte per group |

## Verification
Suppose the key tracker holds a wrong step. Then cfg_mode rises one write too early or never rises. It also fails to fall when an exit write arrives. This shows on the pin in the cycle after the offending index write, so the bench checks cfg_mode after each key byte and after every wrong fourth byte. A wrong index or selector value, or a mis-decoded bank entry, shows on the next data read one cycle later. It also shows on the gpio_base, gpio_oe and gpio_simple pins from the cycle after the write. Reading back all 256 register numbers catches aliasing between bank entries.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [2:0] {
    UL_IDLE,
    UL_K1,
    UL_K2,
    UL_K3,
    UL_OPEN
  } unlock_st_e;

  localparam logic [7:0] REG_EXIT    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;
  localparam logic [7:0] REG_BASE_HI = 8'h62;
  localparam logic [7:0] REG_BASE_LO = 8'h63;
  localparam logic [7:0] REG_SIMPLE0 = 8'hC0;
  localparam logic [7:0] REG_OE0     = 8'hC8;
  localparam logic [7:0] LDN_GPIO    = 8'h07;
  localparam logic [7:0] EXIT_VALUE  = 8'h02;
  localparam logic [7:0] KEY_FIRST   = 8'h87;

  // Expected key byte for each step of the unlock sequence.
  function automatic logic [7:0] key_at(input unlock_st_e st);
    case (st)
      UL_IDLE: key_at = 8'h87;
      UL_K1:   key_at = 8'h01;
      default: key_at = 8'h55;
    endcase
  endfunction

endpackage

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       exit_req,
  output logic       unlocked
);

  unlock_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= UL_IDLE;
    end else if (st_q == UL_OPEN) begin
      if (exit_req) st_q <= UL_IDLE;
    end else if (key_wr) begin
      if (key_byte == key_at(st_q)) begin
        case (st_q)
          UL_IDLE: st_q <= UL_K1;
          UL_K1:   st_q <= UL_K2;
          UL_K2:   st_q <= UL_K3;
          default: st_q <= UL_OPEN;
        endcase
      end else if (key_byte == KEY_FIRST) begin
        st_q <= UL_K1;
      end else begin
        st_q <= UL_IDLE;
      end
    end
  end

  assign unlocked = (st_q == UL_OPEN);

endmodule

// File: rtl/sio_gpio_bank.sv
module sio_gpio_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_SIMPLE = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [7:0]              reg_addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic [15:0]             base_o,
  output logic [NUM_GROUPS*8-1:0] oe_o,
  output logic [NUM_SIMPLE*8-1:0] simple_o
);

  logic [7:0] base_hi_q, base_lo_q;
  logic [7:0] oe_q     [NUM_GROUPS];
  logic [7:0] simple_q [NUM_SIMPLE];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi_q <= '0;
      base_lo_q <= '0;
      for (int g = 0; g < NUM_GROUPS; g++) oe_q[g] <= '0;
      for (int g = 0; g < NUM_SIMPLE; g++) simple_q[g] <= '0;
    end else if (wr_en) begin
      if (reg_addr == REG_BASE_HI) base_hi_q <= wdata;
      if (reg_addr == REG_BASE_LO) base_lo_q <= wdata;
      for (int g = 0; g < NUM_GROUPS; g++)
        if (reg_addr == REG_OE0 + 8'(g)) oe_q[g] <= wdata;
      for (int g = 0; g < NUM_SIMPLE; g++)
        if (reg_addr == REG_SIMPLE0 + 8'(g)) simple_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (reg_addr == REG_BASE_HI) rdata = base_hi_q;
    if (reg_addr == REG_BASE_LO) rdata = base_lo_q;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (reg_addr == REG_OE0 + 8'(g)) rdata = oe_q[g];
    for (int g = 0; g < NUM_SIMPLE; g++)
      if (reg_addr == REG_SIMPLE0 + 8'(g)) rdata = simple_q[g];
  end

  assign base_o = {base_hi_q, base_lo_q};

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_oe_out
    assign oe_o[g*8 +: 8] = oe_q[g];
  end
  for (genvar g = 0; g < NUM_SIMPLE; g++) begin : g_simple_out
    assign simple_o[g*8 +: 8] = simple_q[g];
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [15:0]     CHIP_ID    = 16'h8728,
  parameter logic [3:0]      CHIP_REV   = 4'h3,
  parameter int              NUM_GROUPS = 8,
  parameter int              NUM_SIMPLE = 5,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = ADDR_W'(16'h002E),
  parameter logic [ADDR_W-1:0] DATA_ADDR  = ADDR_W'(16'h002F)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    io_wr,
  input  logic                    io_rd,
  input  logic [ADDR_W-1:0]       io_addr,
  input  logic [7:0]              io_wdata,
  output logic [7:0]              io_rdata,
  output logic                    io_rvalid,
  output logic                    cfg_mode,
  output logic [15:0]             gpio_base,
  output logic [NUM_GROUPS*8-1:0] gpio_oe,
  output logic [NUM_SIMPLE*8-1:0] gpio_simple
);

  logic       hit_idx, hit_dat;
  logic       idx_wr, dat_wr, exit_req, bank_wr, gpio_sel;
  logic [7:0] index_q, ldn_q, bank_rdata, rd_mux;

  assign hit_idx  = (io_addr == INDEX_ADDR);
  assign hit_dat  = (io_addr == DATA_ADDR);
  assign idx_wr   = io_wr && hit_idx;
  assign dat_wr   = io_wr && hit_dat && cfg_mode;
  assign gpio_sel = (ldn_q == LDN_GPIO);
  assign exit_req = dat_wr && (index_q == REG_EXIT) && (io_wdata == EXIT_VALUE);
  assign bank_wr  = dat_wr && gpio_sel;

  sio_unlock_fsm u_unlock (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (idx_wr && !cfg_mode),
    .key_byte (io_wdata),
    .exit_req (exit_req),
    .unlocked (cfg_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_wr && cfg_mode) index_q <= io_wdata;
      if (dat_wr && index_q == REG_LDN) ldn_q <= io_wdata;
    end
  end

  sio_gpio_bank #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_SIMPLE (NUM_SIMPLE)
  ) u_gpio_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bank_wr),
    .reg_addr (index_q),
    .wdata    (io_wdata),
    .rdata    (bank_rdata),
    .base_o   (gpio_base),
    .oe_o     (gpio_oe),
    .simple_o (gpio_simple)
  );

  always_comb begin
    rd_mux = 8'hFF;
    if (hit_idx) begin
      rd_mux = cfg_mode ? index_q : 8'hFF;
    end else if (hit_dat && cfg_mode) begin
      case (index_q)
        REG_LDN:   rd_mux = ldn_q;
        REG_ID_HI: rd_mux = CHIP_ID[15:8];
        REG_ID_LO: rd_mux = CHIP_ID[7:0];
        REG_REV:   rd_mux = {4'h0, CHIP_REV};
        default:   rd_mux = gpio_sel ? bank_rdata : 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_rd && (hit_idx || hit_dat);
      if (io_rd) io_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int              ADDR_W     = 16,
  parameter logic [15:0]     CHIP_ID    = 16'h8728,
  parameter int              NUM_GROUPS = 8,
  parameter int              NUM_SIMPLE = 5,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = ADDR_W'(16'h002E),
  parameter logic [ADDR_W-1:0] DATA_ADDR  = ADDR_W'(16'h002F)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    io_wr,
  input logic                    io_rd,
  input logic [ADDR_W-1:0]       io_addr,
  input logic [7:0]              io_wdata,
  input logic [7:0]              io_rdata,
  input logic                    io_rvalid,
  input logic                    cfg_mode,
  input logic [15:0]             gpio_base,
  input logic [NUM_GROUPS*8-1:0] gpio_oe,
  input logic [NUM_SIMPLE*8-1:0] gpio_simple,
  input logic [7:0]              index_q
);

  assert_open_after_key_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mode) |-> $past(io_wr && io_addr == INDEX_ADDR && io_wdata == 8'h55));

  assert_locked_read_ff_R3: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == DATA_ADDR && !cfg_mode) |=> io_rdata == 8'hFF);

  assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == DATA_ADDR && !cfg_mode)
      |=> ($stable(gpio_base) && $stable(gpio_oe) && $stable(gpio_simple)));

  assert_exit_closes_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && io_wr && io_addr == DATA_ADDR && index_q == 8'h02 && io_wdata == 8'h02)
      |=> !cfg_mode);

  assert_id_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && io_rd && io_addr == DATA_ADDR && index_q == 8'h20)
      |=> io_rdata == CHIP_ID[15:8]);

  assert_rvalid_follows_rd_R10: assert property (@(posedge clk) disable iff (rst)
    (io_rd && (io_addr == INDEX_ADDR || io_addr == DATA_ADDR)) |=> io_rvalid);

  assert_no_rvalid_without_rd_R10: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> !io_rvalid);

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W     (ADDR_W),
  .CHIP_ID    (CHIP_ID),
  .NUM_GROUPS (NUM_GROUPS),
  .NUM_SIMPLE (NUM_SIMPLE),
  .INDEX_ADDR (INDEX_ADDR),
  .DATA_ADDR  (DATA_ADDR)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_addr     (io_addr),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .io_rvalid   (io_rvalid),
  .cfg_mode    (cfg_mode),
  .gpio_base   (gpio_base),
  .gpio_oe     (gpio_oe),
  .gpio_simple (gpio_simple),
  .index_q     (index_q)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;
  localparam int NS = 5;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;
  localparam logic [15:0] ID  = 16'h8728;
  localparam logic [3:0]  REV = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid, cfg_mode;
  logic [15:0] gpio_base;
  logic [NG*8-1:0] gpio_oe;
  logic [NS*8-1:0] gpio_simple;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_base = '0;
  logic [7:0]  m_ldn  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port #(.CHIP_ID(ID), .CHIP_REV(REV), .NUM_GROUPS(NG), .NUM_SIMPLE(NS)) dut_i (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .cfg_mode(cfg_mode), .gpio_base(gpio_base), .gpio_oe(gpio_oe),
    .gpio_simple(gpio_simple)
  );

  function automatic logic [7:0] oe_pat(input int g);
    return 8'(8'h3C ^ (g * 37));
  endfunction
  function automatic logic [7:0] sim_pat(input int g);
    return 8'(8'hF0 + g * 3);
  endfunction

  function automatic logic [7:0] exp_data(input int r, input logic [7:0] ldn,
                                          input logic [15:0] base, input logic loaded);
    if (r == 8'h07) return ldn;
    if (r == 8'h20) return ID[15:8];
    if (r == 8'h21) return ID[7:0];
    if (r == 8'h22) return {4'h0, REV};
    if (ldn != 8'h07) return 8'h00;
    if (r == 8'h62) return base[15:8];
    if (r == 8'h63) return base[7:0];
    if (r >= 8'hC8 && r < 8'hC8 + NG) return loaded ? oe_pat(r - 8'hC8) : 8'h00;
    if (r >= 8'hC0 && r < 8'hC0 + NS) return loaded ? sim_pat(r - 8'hC0) : 8'h00;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic iow(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic ior(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
    chk("R10 rvalid after read", 64'(io_rvalid), 64'd1);
  endtask

  task automatic cfg_wr(input logic [7:0] r, input logic [7:0] v);
    iow(IDX, r);
    iow(DAT, v);
  endtask

  task automatic cfg_rd(input logic [7:0] r, output logic [7:0] v);
    iow(IDX, r);
    ior(DAT, v);
  endtask

  task automatic unlock();
    iow(IDX, 8'h87); iow(IDX, 8'h01); iow(IDX, 8'h55); iow(IDX, 8'h55);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 cfg_mode reset", 64'(cfg_mode), 64'd0);
    chk("R12 base reset", 64'(gpio_base), 64'd0);
    chk("R12 oe reset", 64'(gpio_oe), 64'd0);
    chk("R12 simple reset", 64'(gpio_simple), 64'd0);
    chk("R10 rvalid idle", 64'(io_rvalid), 64'd0);

    // R3 / R11 locked behaviour
    ior(DAT, v); chk("R3 locked data read", 64'(v), 64'hFF);
    ior(IDX, v); chk("R11 locked index read", 64'(v), 64'hFF);
    @(negedge clk); chk("R10 rvalid drops", 64'(io_rvalid), 64'd0);
    iow(DAT, 8'h07);
    chk("R3 locked write no open", 64'(cfg_mode), 64'd0);

    // R1 key sequence, step by step
    iow(IDX, 8'h87); chk("R1 step1", 64'(cfg_mode), 64'd0);
    iow(IDX, 8'h01); chk("R1 step2", 64'(cfg_mode), 64'd0);
    iow(IDX, 8'h55); chk("R1 step3", 64'(cfg_mode), 64'd0);
    iow(IDX, 8'h55); chk("R1 step4 opens", 64'(cfg_mode), 64'd1);

    ior(IDX, v); chk("R11 open index read", 64'(v), 64'h00);
    cfg_rd(8'h07, v); chk("R3 locked ldn write ignored", 64'(v), 64'h00);

    // R6 identity
    cfg_rd(8'h20, v); chk("R6 id high", 64'(v), 64'(ID[15:8]));
    cfg_rd(8'h21, v); chk("R6 id low", 64'(v), 64'(ID[7:0]));
    cfg_rd(8'h22, v); chk("R6 revision", 64'(v), 64'({4'h0, REV}));
    cfg_wr(8'h20, 8'h11); cfg_wr(8'h21, 8'h22); cfg_wr(8'h22, 8'hFF);
    cfg_rd(8'h20, v); chk("R6 id high write ignored", 64'(v), 64'(ID[15:8]));
    cfg_rd(8'h21, v); chk("R6 id low write ignored", 64'(v), 64'(ID[7:0]));
    cfg_rd(8'h22, v); chk("R6 revision write ignored", 64'(v), 64'({4'h0, REV}));

    // R9 other device: bank hidden
    cfg_wr(8'h07, 8'h05);
    cfg_rd(8'h07, v); chk("R5 ldn readback", 64'(v), 64'h05);
    cfg_wr(8'h62, 8'hAB); cfg_wr(8'hC8, 8'hCD);
    chk("R9 base untouched", 64'(gpio_base), 64'd0);
    chk("R9 oe untouched", 64'(gpio_oe), 64'd0);
    cfg_rd(8'h62, v); chk("R9 hidden read", 64'(v), 64'h00);

    // R7 / R8 program the GPIO bank
    cfg_wr(8'h07, 8'h07); m_ldn = 8'h07;
    m_base = 16'h0A30;
    cfg_wr(8'h62, m_base[15:8]); cfg_wr(8'h63, m_base[7:0]);
    chk("R7 base output", 64'(gpio_base), 64'(m_base));
    for (int g = 0; g < NG; g++) cfg_wr(8'(8'hC8 + g), oe_pat(g));
    for (int g = 0; g < NS; g++) cfg_wr(8'(8'hC0 + g), sim_pat(g));
    for (int g = 0; g < NG; g++)
      chk("R8 oe group output", 64'(gpio_oe[g*8 +: 8]), 64'(oe_pat(g)));
    for (int g = 0; g < NS; g++)
      chk("R8 simple group output", 64'(gpio_simple[g*8 +: 8]), 64'(sim_pat(g)));

    // Sweep every register number (R5 R6 R7 R8 R9)
    for (int r = 0; r < 256; r++) begin
      cfg_rd(8'(r), v);
      chk("R9 register sweep", 64'(v), 64'(exp_data(r, m_ldn, m_base, 1'b1)));
    end

    // R4 exit
    cfg_wr(8'h02, 8'h03); chk("R4 wrong exit value", 64'(cfg_mode), 64'd1);
    cfg_wr(8'h02, 8'h02); chk("R4 exit closes", 64'(cfg_mode), 64'd0);
    ior(DAT, v); chk("R3 closed data read", 64'(v), 64'hFF);
    iow(DAT, 8'h00);
    chk("R3 closed write oe kept", 64'(gpio_oe[7:0]), 64'(oe_pat(0)));

    // R2 wrong fourth byte sweep
    for (int b = 0; b < 256; b++) begin
      if (b != 8'h55) begin
        iow(IDX, 8'h87); iow(IDX, 8'h01); iow(IDX, 8'h55); iow(IDX, 8'(b));
        chk("R2 wrong fourth byte", 64'(cfg_mode), 64'd0);
      end
    end
    iow(IDX, 8'h00);
    iow(IDX, 8'h87); iow(IDX, 8'h01); iow(IDX, 8'h00); iow(IDX, 8'h55); iow(IDX, 8'h55);
    chk("R2 broken sequence", 64'(cfg_mode), 64'd0);
    iow(IDX, 8'h87); iow(IDX, 8'h87); iow(IDX, 8'h01); iow(IDX, 8'h55); iow(IDX, 8'h55);
    chk("R2 repeated first byte", 64'(cfg_mode), 64'd1);
    ior(IDX, v); chk("R11 index kept across exit", 64'(v), 64'h02);
    cfg_wr(8'h02, 8'h02);
    iow(IDX, 8'h87); iow(IDX, 8'h01); iow(IDX, 8'h87); iow(IDX, 8'h01);
    iow(IDX, 8'h55); iow(IDX, 8'h55);
    chk("R2 restart mid sequence", 64'(cfg_mode), 64'd1);
    cfg_rd(8'hC9, v); chk("R8 state kept after relock", 64'(v), 64'(oe_pat(1)));

    // R12 reset clears bank
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R12 reset closes", 64'(cfg_mode), 64'd0);
    chk("R12 reset oe", 64'(gpio_oe), 64'd0);
    unlock();
    cfg_rd(8'h07, v); chk("R12 reset ldn", 64'(v), 64'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule